// File: doc/BRIEF.md
# Time-Counter Static Instruction Scheduler

This block sits between instruction decode and the execution units. It fixes the dispatch cycle of every instruction when the instruction arrives, instead of waking and selecting instructions later. It does not speculate and does not rename registers. A free-running cycle counter is the only time base. Every planned event is stored as a value of that counter, and every comparison is made modulo the counter width.

Three pieces of state drive the choice of cycle. A per-register table holds the cycle at which each pending result is written back, and the latest cycle at which a pending instruction reads that register. A reservation map covers the next 32 cycles. Each slot of the map marks whether the source-read slot and the write-back port of that cycle are already taken. An arriving instruction receives the smallest offset `k` (at least 1) that respects the register timing, finds both resources free, and lets the write-back fit inside the window. The instruction is then parked in a small issue queue. It leaves the queue in the cycle when the counter equals its planned cycle.

The execution units have fixed latencies: 1 cycle for the ALU, 3 for the multiplier and 4 for the load/store unit. Because the latencies are fixed, the cycles during a load's latency window can be given to independent work.

Top module: `tcs_sched`

## Requirements
- R1: After reset the counter reads 0, `disp_valid` is low, `in_ready` is high, and every register counts as ready. An instruction accepted in the first cycle after reset dispatches exactly one cycle later.
- R2: `now_cycle` rises by one every clock and wraps from 255 to 0. Scheduling stays correct across the wrap.
- R3: An instruction accepted while the counter reads `T` is dispatched in the cycle where the counter reads `T+k`, with `k` the smallest value of at least 1 that meets R4 to R10. The dispatch shows `disp_valid` high, the instruction's tag, and its unit code. The unit codes are 0 for the ALU (latency 1), 1 for the multiplier (latency 3) and 2 for load/store (latency 4). Code 3 is treated as ALU.
- R4: A reader dispatches no earlier than the write-back cycle (issue plus latency) of a pending producer of either of its sources.
- R5: The write-back cycle of a new instruction comes strictly after the latest pending read of its destination register.
- R6: The write-back cycle of a new instruction comes strictly after any pending write-back to the same destination register.
- R7: At most one instruction dispatches per cycle. An instruction whose earliest cycle already holds a dispatch moves to the next cycle that is free.
- R8: No two instructions write back in the same cycle. The write-back cycle is issue plus latency.
- R9: An independent instruction accepted after a load's consumer can dispatch inside the load's latency window, ahead of that consumer.
- R10: The write-back offset `k + latency` may not exceed 31. While no such `k` exists, `in_ready` stays low and the instruction is taken once the plan fits.
- R11: While 8 instructions are waiting, `in_ready` is low. A queue entry whose instruction dispatches in the current cycle counts as free in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decoded instruction offered |
| in_unit | input | 2 | Unit code of the offered instruction |
| in_src_a | input | 4 | First source register |
| in_src_b | input | 4 | Second source register |
| in_dst | input | 4 | Destination register |
| in_tag | input | 6 | Instruction tag |
| in_ready | output | 1 | Instruction taken at this clock edge when `in_valid` is high |
| disp_valid | output | 1 | An instruction fires this cycle |
| disp_unit | output | 2 | Unit code of the firing instruction |
| disp_tag | output | 6 | Tag of the firing instruction |
| now_cycle | output | 8 | Current time-counter value |

## Verification
`in_ready` is combinational in the offered instruction. The bench therefore compares it with its own model 1 ns after it drives the inputs, in the same cycle. An instruction taken when the counter reads `T` has its dispatch due in the cycle whose counter reads `T+k`, with no further register delay. The driver files the expected tag and unit under that absolute cycle number. The monitor looks at the dispatch outputs at every falling edge and checks them against whatever is filed for that cycle. A dispatch with nothing filed for its cycle is a failure, and so is a filed item with no dispatch. The counter is checked at every falling edge against the bench's own cycle count modulo 256.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int CNT_W  = 8;
  localparam int SLOT_W = 5;
  localparam int WIN    = 1 << SLOT_W;

  typedef logic [CNT_W-1:0]  tick_t;
  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [1:0] {
    UNIT_ALU = 2'd0,
    UNIT_MUL = 2'd1,
    UNIT_LSU = 2'd2,
    UNIT_RSV = 2'd3
  } unit_e;

  // Cycles from now until when, wrap-safe modulo 2**CNT_W.
  function automatic tick_t ticks_until(input tick_t when, input tick_t now);
    return tick_t'(when - now);
  endfunction

  // Reservation-map slot of the cycle that lies ahead cycles after now.
  function automatic slot_t slot_at(input tick_t now, input int ahead);
    tick_t t;
    t = tick_t'(now + tick_t'(ahead));
    return t[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/tcs_timer.sv
module tcs_timer
  import tcs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output tick_t now
);
  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= tick_t'(now + tick_t'(1));
  end

  // R2
  counter_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> now == tick_t'($past(now) + tick_t'(1)));
endmodule

// File: rtl/tcs_scoreboard.sv
module tcs_scoreboard
  import tcs_pkg::*;
#(
  parameter int NREG = 16,
  parameter int RW   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  tick_t         now,
  input  logic [RW-1:0] q_a,
  input  logic [RW-1:0] q_b,
  input  logic [RW-1:0] q_d,
  input  logic          upd,
  input  tick_t         rd_at,
  input  tick_t         wr_at,
  output tick_t         off_a,
  output tick_t         off_b,
  output tick_t         off_dw,
  output tick_t         off_dr
);
  logic [NREG-1:0] wpend, rpend;
  tick_t wtime [NREG];
  tick_t rtime [NREG];

  always_comb begin
    off_a  = wpend[q_a] ? ticks_until(wtime[q_a], now) : '0;
    off_b  = wpend[q_b] ? ticks_until(wtime[q_b], now) : '0;
    off_dw = wpend[q_d] ? ticks_until(wtime[q_d], now) : '0;
    off_dr = rpend[q_d] ? ticks_until(rtime[q_d], now) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wpend <= '0;
      rpend <= '0;
      for (int r = 0; r < NREG; r++) begin
        wtime[r] <= '0;
        rtime[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (upd && RW'(r) == q_d) begin
          wpend[r] <= 1'b1;
          wtime[r] <= wr_at;
        end else if (wpend[r] && wtime[r] == now) begin
          wpend[r] <= 1'b0;
        end
        if (upd && (RW'(r) == q_a || RW'(r) == q_b) &&
            (!rpend[r] || ticks_until(rd_at, now) > ticks_until(rtime[r], now))) begin
          rpend[r] <= 1'b1;
          rtime[r] <= rd_at;
        end else if (rpend[r] && rtime[r] == now) begin
          rpend[r] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tcs_resmap.sv
module tcs_resmap
  import tcs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  tick_t         now,
  input  logic [SLOT_W:0] dep,
  input  slot_t         lat,
  input  logic          commit,
  output logic          found,
  output slot_t         pick
);
  logic [WIN-1:0] rd_busy, wr_busy, cand;

  for (genvar k = 0; k < WIN; k++) begin : g_cand
    localparam int K = k;
    if (k == 0) begin : g_now
      assign cand[k] = 1'b0;
    end else begin : g_ahead
      assign cand[k] = (K >= int'(dep)) && (K + int'(lat) <= WIN - 1) &&
                       !rd_busy[slot_at(now, K)] &&
                       !wr_busy[slot_at(now, K + int'(lat))];
    end
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = WIN - 1; k >= 1; k--) begin
      if (cand[k]) begin
        found = 1'b1;
        pick  = slot_t'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_busy <= '0;
      wr_busy <= '0;
    end else begin
      rd_busy[slot_at(now, 0)] <= 1'b0;
      wr_busy[slot_at(now, 0)] <= 1'b0;
      if (commit) begin
        rd_busy[slot_at(now, int'(pick))]              <= 1'b1;
        wr_busy[slot_at(now, int'(pick) + int'(lat))]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcs_queue.sv
module tcs_queue
  import tcs_pkg::*;
#(
  parameter int QD    = 8,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  tick_t            now,
  input  logic             push,
  input  tick_t            push_at,
  input  unit_e            push_unit,
  input  logic [TAG_W-1:0] push_tag,
  output logic             has_room,
  output logic             fire_valid,
  output unit_e            fire_unit,
  output logic [TAG_W-1:0] fire_tag
);
  localparam int IW = (QD > 1) ? $clog2(QD) : 1;

  logic [QD-1:0]    live, hit;
  tick_t            at_t [QD];
  unit_e            un   [QD];
  logic [TAG_W-1:0] tg   [QD];
  logic [IW-1:0]    wsel;

  always_comb begin
    has_room   = 1'b0;
    wsel       = '0;
    fire_unit  = UNIT_ALU;
    fire_tag   = '0;
    for (int i = QD - 1; i >= 0; i--) begin
      hit[i] = live[i] && at_t[i] == now;
      if (!live[i] || hit[i]) begin
        has_room = 1'b1;
        wsel     = IW'(i);
      end
      if (hit[i]) begin
        fire_unit = un[i];
        fire_tag  = tg[i];
      end
    end
    fire_valid = |hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      for (int i = 0; i < QD; i++) begin
        at_t[i] <= '0;
        un[i]   <= UNIT_ALU;
        tg[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < QD; i++) begin
        if (push && wsel == IW'(i)) begin
          live[i] <= 1'b1;
          at_t[i] <= push_at;
          un[i]   <= push_unit;
          tg[i]   <= push_tag;
        end else if (hit[i]) begin
          live[i] <= 1'b0;
        end
      end
    end
  end

  // R7
  single_fire_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(hit));
endmodule

// File: rtl/tcs_sched.sv
module tcs_sched
  import tcs_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int TAG_W   = 6,
  parameter int QDEPTH  = 8,
  parameter int LAT_ALU = 1,
  parameter int LAT_MUL = 3,
  parameter int LAT_LSU = 4,
  localparam int RW     = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_unit,
  input  logic [RW-1:0]    in_src_a,
  input  logic [RW-1:0]    in_src_b,
  input  logic [RW-1:0]    in_dst,
  input  logic [TAG_W-1:0] in_tag,
  output logic             in_ready,
  output logic             disp_valid,
  output logic [1:0]       disp_unit,
  output logic [TAG_W-1:0] disp_tag,
  output logic [CNT_W-1:0] now_cycle
);
  function automatic slot_t lat_of(input unit_e u);
    case (u)
      UNIT_MUL: return slot_t'(LAT_MUL);
      UNIT_LSU: return slot_t'(LAT_LSU);
      default:  return slot_t'(LAT_ALU);
    endcase
  endfunction

  tick_t now, off_a, off_b, off_dw, off_dr, issue_at, wb_at;
  slot_t lat, pick;
  logic [SLOT_W:0] dep;
  logic found, has_room, accept;
  unit_e fire_unit, cur_unit;

  assign cur_unit = unit_e'(in_unit);
  assign lat      = lat_of(cur_unit);
  assign in_ready = found && has_room;
  assign accept   = in_valid && in_ready;
  assign issue_at = tick_t'(now + tick_t'(pick));
  assign wb_at    = tick_t'(issue_at + tick_t'(lat));
  assign now_cycle = now;

  // Earliest offset allowed by register timing (RAW, WAR, WAW), at least 1.
  always_comb begin
    int need;
    need = 1;
    if (int'(off_a) > need) need = int'(off_a);
    if (int'(off_b) > need) need = int'(off_b);
    if (int'(off_dr) + 1 - int'(lat) > need) need = int'(off_dr) + 1 - int'(lat);
    if (int'(off_dw) + 1 - int'(lat) > need) need = int'(off_dw) + 1 - int'(lat);
    dep = (SLOT_W + 1)'(need);
  end

  tcs_timer u_timer (.clk(clk), .rst(rst), .now(now));

  tcs_scoreboard #(.NREG(NREG), .RW(RW)) u_sb (
    .clk(clk), .rst(rst), .now(now),
    .q_a(in_src_a), .q_b(in_src_b), .q_d(in_dst),
    .upd(accept), .rd_at(issue_at), .wr_at(wb_at),
    .off_a(off_a), .off_b(off_b), .off_dw(off_dw), .off_dr(off_dr)
  );

  tcs_resmap u_map (
    .clk(clk), .rst(rst), .now(now), .dep(dep), .lat(lat),
    .commit(accept), .found(found), .pick(pick)
  );

  tcs_queue #(.QD(QDEPTH), .TAG_W(TAG_W)) u_q (
    .clk(clk), .rst(rst), .now(now),
    .push(accept), .push_at(issue_at), .push_unit(cur_unit), .push_tag(in_tag),
    .has_room(has_room), .fire_valid(disp_valid), .fire_unit(fire_unit),
    .fire_tag(disp_tag)
  );

  assign disp_unit = fire_unit;

  // R4
  raw_wait_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> int'(pick) >= int'(off_a) && int'(pick) >= int'(off_b));
  // R5
  war_guard_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> int'(pick) + int'(lat) > int'(off_dr));
  // R6
  waw_guard_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> int'(pick) + int'(lat) > int'(off_dw));
  // R10
  window_fit_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> int'(pick) + int'(lat) < WIN);
endmodule

// File: tb/tb_tcs_sched.sv
module tb_tcs_sched;
  localparam int NREG = 16;
  localparam int QD   = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_unit = '0;
  logic [3:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic [5:0] in_tag = '0;
  logic in_ready, disp_valid;
  logic [1:0] disp_unit;
  logic [5:0] disp_tag;
  logic [7:0] now_cycle;

  tcs_sched dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst), .in_tag(in_tag),
    .in_ready(in_ready), .disp_valid(disp_valid), .disp_unit(disp_unit),
    .disp_tag(disp_tag), .now_cycle(now_cycle)
  );

  always #2 clk = ~clk;

  typedef struct { int tag; int unit; string rq; } exp_t;
  exp_t exp_q [int];
  bit   rdres [int];
  bit   wrres [int];
  int   wready [NREG];
  int   rlast  [NREG];
  int   cyc = 0, n_chk = 0, n_bad = 0;
  bit   live_run = 0, done = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, expv);
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic int lat_of(input int u);
    return (u == 1) ? 3 : (u == 2) ? 4 : 1;
  endfunction

  always @(posedge clk) if (live_run) cyc++;

  // Monitor: pops the item due in this cycle and compares the dispatch port.
  always @(negedge clk) begin
    if (live_run && !done) begin
      check(int'(now_cycle) == cyc % 256, "R2", "counter", int'(now_cycle), cyc % 256);
      if (exp_q.exists(cyc)) begin
        check(disp_valid == 1'b1, exp_q[cyc].rq, "dispatch valid", int'(disp_valid), 1);
        check(int'(disp_tag) == exp_q[cyc].tag, exp_q[cyc].rq, "dispatch tag",
              int'(disp_tag), exp_q[cyc].tag);
        check(int'(disp_unit) == exp_q[cyc].unit, exp_q[cyc].rq, "dispatch unit",
              int'(disp_unit), exp_q[cyc].unit);
        exp_q.delete(cyc);
      end else if (disp_valid) begin
        check(1'b0, "R7", "unplanned dispatch tag", int'(disp_tag), -1);
      end
    end
  end

  // Driver: offers one instruction, predicts in_ready and the dispatch cycle.
  task automatic send(input int unit, input int sa, input int sb, input int d,
                      input int tag, input string rq,
                      output int stalls, output bit sawfull);
    int t, lat, dep, k;
    bit fnd, ok;
    stalls = 0;
    sawfull = 0;
    @(negedge clk);
    in_valid = 1'b1; in_unit = 2'(unit); in_src_a = 4'(sa); in_src_b = 4'(sb);
    in_dst = 4'(d); in_tag = 6'(tag);
    forever begin
      #1;
      t = cyc; lat = lat_of(unit); dep = 1; k = 0; fnd = 0;
      if (wready[sa] - t > dep) dep = wready[sa] - t;
      if (wready[sb] - t > dep) dep = wready[sb] - t;
      if (rlast[d] + 1 - lat - t > dep) dep = rlast[d] + 1 - lat - t;
      if (wready[d] + 1 - lat - t > dep) dep = wready[d] + 1 - lat - t;
      for (int j = dep; j + lat <= 31; j++) begin
        if (!fnd && !rdres.exists(t + j) && !wrres.exists(t + j + lat)) begin
          fnd = 1; k = j;
        end
      end
      ok = fnd && exp_q.num() < QD;
      check(in_ready == ok, rq, "in_ready", int'(in_ready), int'(ok));
      if (ok) begin
        rdres[t + k] = 1;
        wrres[t + k + lat] = 1;
        wready[d] = t + k + lat;
        if (t + k > rlast[sa]) rlast[sa] = t + k;
        if (t + k > rlast[sb]) rlast[sb] = t + k;
        exp_q[t + k] = '{tag: tag, unit: unit, rq: rq};
        break;
      end
      if (!in_ready) stalls++;
      if (exp_q.num() >= QD) sawfull = 1;
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      finish_up();
    end
  end

  initial begin
    int st, tot;
    bit sf, anyfull;
    for (int r = 0; r < NREG; r++) begin wready[r] = -1; rlast[r] = -1; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(disp_valid == 1'b0, "R1", "disp_valid in reset", int'(disp_valid), 0);
    check(now_cycle == 8'd0, "R1", "counter in reset", int'(now_cycle), 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    live_run = 1;

    // R1/R3: all registers ready, independent ALU goes one cycle later
    send(0, 2, 3, 1, 1, "R3", st, sf);
    idle(40);
    // R4/R9: load, its consumer, then independent work inside the window
    send(2, 5, 5, 4, 2, "R4", st, sf);
    send(0, 4, 4, 6, 3, "R4", st, sf);
    send(0, 8, 8, 7, 4, "R9", st, sf);
    idle(40);
    // R5: late read of r12 delays a later write to r12
    send(2, 0, 0, 10, 5, "R5", st, sf);
    send(0, 10, 12, 11, 6, "R5", st, sf);
    send(0, 0, 0, 12, 7, "R5", st, sf);
    idle(40);
    // R6: short write after a long write to the same register
    send(2, 0, 0, 13, 8, "R6", st, sf);
    send(0, 0, 0, 13, 9, "R6", st, sf);
    idle(40);
    // R7: two readers of one load result collide on a read slot
    send(2, 0, 0, 3, 10, "R7", st, sf);
    send(0, 3, 3, 5, 11, "R7", st, sf);
    send(0, 3, 3, 14, 12, "R7", st, sf);
    idle(40);
    // R8: multiplier would write back with the load
    send(2, 0, 0, 2, 13, "R8", st, sf);
    send(1, 0, 0, 9, 14, "R8", st, sf);
    idle(40);
    // R10: dependent load chain runs past the window
    tot = 0;
    for (int i = 0; i < 10; i++) begin
      send(2, 1, 1, 1, 20 + i, "R10", st, sf);
      tot += st;
    end
    check(tot > 0, "R10", "window stall cycles", tot, 1);
    // R11: far readers fill the queue
    tot = 0; anyfull = 0;
    for (int i = 0; i < 10; i++) begin
      send(0, 1, 1, 2 + i, 40 + i, "R11", st, sf);
      tot += st;
      anyfull |= sf;
    end
    check(anyfull && tot > 0, "R11", "queue-full stall seen", int'(anyfull), 1);
    idle(200);
    // R2: same dependency pattern across the counter wrap
    send(2, 5, 5, 4, 60, "R2", st, sf);
    send(0, 4, 4, 6, 61, "R2", st, sf);
    send(0, 8, 8, 7, 62, "R2", st, sf);
    idle(60);
    check(exp_q.num() == 0, "R3", "items never dispatched", exp_q.num(), 0);
    finish_up();
  end
endmodule